// File: doc/BRIEF.md
# SCSI Target Selection Detector

This block sits beside the bus drivers of a SCSI target and watches the selection lines. It decides when the host has chosen one of the target IDs configured locally. When that happens it captures a status word naming the chosen ID and offers it to the controller. The controller reads it through a valid/ready handshake. While `sts_valid` is high and `sts_ready` is low, the word is frozen. A selection that appears while a word is still pending is not captured. The word is released one cycle after the clock edge that sees both `sts_valid` and `sts_ready` high.

The controller can then ask the block to take the bus. The block first enables its control drivers, with the phase lines C/D and MSG at their inactive level. One cycle later it asserts BSY. It then waits a settle time of about 100 ns and samples ATN:
- If ATN is absent, the host is treated as a legacy host that sends no identify message. The block flags legacy mode and pulses a request to clear the unit-attention indication.
- If ATN is present, legacy mode is cleared.

The block also filters the bus reset line. A reset assertion counts only if RST is still asserted when it is sampled again about 500 ns later. A controller request for bus free clears all selection and takeover state, and so does an accepted bus reset. All bus inputs pass through a two-stage synchroniser, and all delays are cycle counts derived from a clock-period parameter.

Top module: `scsi_sel_detect`

## Requirements
- R1: After `rst_n` is released, `sts_valid`, `sel_latched`, `drv_en`, `drv_bsy`, `atn_flag` and `legacy_mode` are all 0.
- R2: A selection is recognised only on a rising edge of the condition (SEL asserted and BSY not asserted). SEL with BSY asserted captures nothing. The later release of BSY while SEL is held causes the capture.
- R3: Target `t` takes part only if `cfg_tgt_en[t]` is 1 and its 4-bit ID in `cfg_tgt_id[4t+3:4t]` is 7 or less. It matches when `bus_data` bit number ID is 1. Among the matching targets, the lowest index `t` wins. When no target matches, nothing is captured.
- R4: The captured `sts_word` is {bit4 succeeded=1, bit3 ATN=1, bits2:0 ID}. It stays valid and unchanged until accepted with `sts_ready`, and no new selection replaces it while it is pending. `sts_valid` is 0 from the cycle after acceptance.
- R5: While `drv_bsy` is 1, no selection is captured, even with SEL asserted and BSY low on the bus.
- R6: `sel_latched` is set together with a capture and stays set after SEL is dropped. It is cleared only by bus free, bus reset or `rst_n`.
- R7: A `take_req` seen while idle drives `drv_en` to 1 one cycle after the request edge, with `drv_bsy` still 0. `drv_bsy` follows one cycle later. `take_done` pulses for one cycle exactly SETTLE_CYC cycles after `drv_bsy` rises (SETTLE_CYC = ceil(SETTLE_NS/CLK_PERIOD_NS) = 10 by default).
- R8: At the ATN sample, ATN absent gives `legacy_mode`=1, `atn_flag`=0 and a one-cycle `ua_clear` pulse. ATN present gives `legacy_mode`=0, `atn_flag`=1 and no `ua_clear`.
- R9: A rising edge on RST gives a one-cycle `bus_reset_pulse` only if RST is still asserted RST_CYC cycles later (RST_CYC = ceil(RST_FILTER_NS/CLK_PERIOD_NS) = 50 by default). A shorter glitch gives no pulse.
- R10: `bus_free_req` and an accepted bus reset each clear `sts_valid`, `sel_latched`, `atn_flag`, `drv_en`, `drv_bsy` and the takeover sequence. Only the bus reset also clears `legacy_mode`.
- R11: A `take_req` that arrives while a takeover is in progress or held has no effect. In particular, no second `take_done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-release reset |
| bus_sel | input | 1 | SEL line, 1 = asserted |
| bus_bsy | input | 1 | BSY line, 1 = asserted |
| bus_atn | input | 1 | ATN line, 1 = asserted |
| bus_rst | input | 1 | RST line, 1 = asserted |
| bus_data | input | 8 | Data lines, 1 = asserted |
| cfg_tgt_en | input | NUM_TGT | Enable per target slot |
| cfg_tgt_id | input | NUM_TGT*4 | 4-bit bus ID per target slot |
| sts_valid | output | 1 | Status word available |
| sts_ready | input | 1 | Controller accepts status word |
| sts_word | output | 5 | {succeeded, atn, id[2:0]} |
| sel_latched | output | 1 | Sticky selected flag |
| take_req | input | 1 | Request to take BSY |
| bus_free_req | input | 1 | Request to enter bus free |
| drv_en | output | 1 | Control drivers enabled, C/D and MSG inactive |
| drv_bsy | output | 1 | Drive BSY asserted |
| take_done | output | 1 | One-cycle pulse at the ATN sample |
| atn_flag | output | 1 | ATN level seen at the sample |
| legacy_mode | output | 1 | Legacy host detected (no ATN) |
| ua_clear | output | 1 | Pulse: clear unit-attention indication |
| bus_reset_pulse | output | 1 | One-cycle pulse on an accepted bus reset |

## Verification
The bench drives a configuration with a disabled slot, an out-of-range ID whose low bits alias a real data bit, and two matching slots whose index order is the reverse of their ID order. A matcher that masks the ID to three bits, or ranks by ID, captures the wrong target or a phantom one. It holds SEL against an asserted BSY, pulses SEL only briefly, and raises a second selection while a word is pending. A detector that is level-sensitive, lacks the sticky flag, or overwrites pending status would show up in these cases. It also times the enable-then-BSY-then-sample sequence cycle by cycle, tries a second takeover request, feeds a 3-cycle RST glitch and a long RST, and checks that only the bus reset clears legacy mode.

// File: rtl/scsi_sel_pkg.sv
package scsi_sel_pkg;

  localparam int SEL_ID_W = 3;

  typedef struct packed {
    logic                succeeded;
    logic                atn;
    logic [SEL_ID_W-1:0] id;
  } sel_status_t;

  typedef enum logic [1:0] {
    TK_IDLE,
    TK_ARM,
    TK_SETTLE,
    TK_HOLD
  } take_state_t;

  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

endpackage

// File: rtl/ssd_sync.sv
module ssd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ssd_id_match.sv
module ssd_id_match #(
  parameter int NUM_TGT  = 4,
  parameter int CFG_ID_W = 4
) (
  input  logic [7:0]                  data,
  input  logic [NUM_TGT-1:0]          en,
  input  logic [NUM_TGT*CFG_ID_W-1:0] ids,
  output logic                        hit,
  output logic [2:0]                  id
);

  logic [NUM_TGT-1:0] slot_hit;
  logic [2:0]         slot_id [NUM_TGT];

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
    logic [CFG_ID_W-1:0] cur;
    assign cur         = ids[t*CFG_ID_W +: CFG_ID_W];
    assign slot_id[t]  = cur[2:0];
    assign slot_hit[t] = en[t] && (cur <= CFG_ID_W'(7)) && data[cur[2:0]];
  end

  // lowest slot index wins
  always_comb begin
    hit = 1'b0;
    id  = 3'd0;
    for (int t = NUM_TGT - 1; t >= 0; t--) begin
      if (slot_hit[t]) begin
        hit = 1'b1;
        id  = slot_id[t];
      end
    end
  end

endmodule

// File: rtl/ssd_rst_filter.sv
module ssd_rst_filter #(
  parameter int FILT_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_in,
  output logic evt
);

  localparam int CW = $clog2(FILT_CYC + 1);

  logic          prev;
  logic          waiting;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      waiting <= 1'b0;
      cnt     <= '0;
      evt     <= 1'b0;
    end else begin
      prev <= rst_in;
      evt  <= 1'b0;
      if (!waiting) begin
        if (rst_in && !prev) begin
          waiting <= 1'b1;
          cnt     <= '0;
        end
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        waiting <= 1'b0;
        evt     <= rst_in;   // second look decides
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssd_takeover.sv
module ssd_takeover
  import scsi_sel_pkg::*;
#(
  parameter int SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic clear_mode,
  input  logic req,
  input  logic atn_s,
  output logic drv_en,
  output logic drv_bsy,
  output logic done,
  output logic atn_flag,
  output logic legacy,
  output logic ua_clr
);

  localparam int CW = $clog2(SETTLE_CYC + 1);

  take_state_t   st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TK_IDLE;
      cnt      <= '0;
      drv_en   <= 1'b0;
      drv_bsy  <= 1'b0;
      done     <= 1'b0;
      atn_flag <= 1'b0;
      legacy   <= 1'b0;
      ua_clr   <= 1'b0;
    end else begin
      done   <= 1'b0;
      ua_clr <= 1'b0;
      if (clear) begin
        st       <= TK_IDLE;
        cnt      <= '0;
        drv_en   <= 1'b0;
        drv_bsy  <= 1'b0;
        atn_flag <= 1'b0;
        if (clear_mode) legacy <= 1'b0;
      end else begin
        unique case (st)
          TK_IDLE: if (req) begin
            st     <= TK_ARM;
            drv_en <= 1'b1;
          end
          TK_ARM: begin
            st      <= TK_SETTLE;
            drv_bsy <= 1'b1;
            cnt     <= '0;
          end
          TK_SETTLE: begin
            if (cnt == CW'(SETTLE_CYC - 1)) begin
              st       <= TK_HOLD;
              done     <= 1'b1;
              atn_flag <= atn_s;
              legacy   <= !atn_s;
              ua_clr   <= !atn_s;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          TK_HOLD: ;
          default: st <= TK_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect
  import scsi_sel_pkg::*;
#(
  parameter int NUM_TGT       = 4,
  parameter int CFG_ID_W      = 4,
  parameter int CLK_PERIOD_NS = 10,
  parameter int SETTLE_NS     = 100,
  parameter int RST_FILTER_NS = 500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_bsy,
  input  logic                        bus_atn,
  input  logic                        bus_rst,
  input  logic [7:0]                  bus_data,
  input  logic [NUM_TGT-1:0]          cfg_tgt_en,
  input  logic [NUM_TGT*CFG_ID_W-1:0] cfg_tgt_id,
  output logic                        sts_valid,
  input  logic                        sts_ready,
  output logic [4:0]                  sts_word,
  output logic                        sel_latched,
  input  logic                        take_req,
  input  logic                        bus_free_req,
  output logic                        drv_en,
  output logic                        drv_bsy,
  output logic                        take_done,
  output logic                        atn_flag,
  output logic                        legacy_mode,
  output logic                        ua_clear,
  output logic                        bus_reset_pulse
);

  localparam int SETTLE_RAW = ns_to_cycles(SETTLE_NS, CLK_PERIOD_NS);
  localparam int RST_RAW    = ns_to_cycles(RST_FILTER_NS, CLK_PERIOD_NS);
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int RST_CYC    = (RST_RAW < 1) ? 1 : RST_RAW;
  localparam int BUS_W      = 12;

  logic [BUS_W-1:0] bus_raw, bus_s;
  logic             sel_s, bsy_s, atn_s, rst_s;
  logic [7:0]       data_s;

  assign bus_raw = {bus_sel, bus_bsy, bus_atn, bus_rst, bus_data};

  ssd_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign sel_s  = bus_s[11];
  assign bsy_s  = bus_s[10];
  assign atn_s  = bus_s[9];
  assign rst_s  = bus_s[8];
  assign data_s = bus_s[7:0];

  logic       hit;
  logic [2:0] hit_id;

  ssd_id_match #(.NUM_TGT(NUM_TGT), .CFG_ID_W(CFG_ID_W)) u_match (
    .data(data_s), .en(cfg_tgt_en), .ids(cfg_tgt_id), .hit(hit), .id(hit_id)
  );

  logic rst_evt;

  ssd_rst_filter #(.FILT_CYC(RST_CYC)) u_rstf (
    .clk(clk), .rst_n(rst_n), .rst_in(rst_s), .evt(rst_evt)
  );

  logic clear_all;
  assign clear_all = bus_free_req | rst_evt;

  ssd_takeover #(.SETTLE_CYC(SETTLE_CYC)) u_take (
    .clk(clk), .rst_n(rst_n), .clear(clear_all), .clear_mode(rst_evt),
    .req(take_req), .atn_s(atn_s), .drv_en(drv_en), .drv_bsy(drv_bsy),
    .done(take_done), .atn_flag(atn_flag), .legacy(legacy_mode), .ua_clr(ua_clear)
  );

  // selection window: SEL on, BSY off, and not our own BSY
  logic        win, win_q, capture;
  sel_status_t sts_q;

  assign win     = sel_s && !bsy_s && !drv_bsy;
  assign capture = win && !win_q && hit && !sts_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= 1'b0;
      sts_valid   <= 1'b0;
      sts_q       <= '0;
      sel_latched <= 1'b0;
    end else begin
      win_q <= win;
      if (clear_all) begin
        sts_valid   <= 1'b0;
        sts_q       <= '0;
        sel_latched <= 1'b0;
      end else begin
        if (sts_valid && sts_ready) sts_valid <= 1'b0;
        if (capture) begin
          sts_valid       <= 1'b1;
          sts_q.succeeded <= 1'b1;
          sts_q.atn       <= 1'b1;
          sts_q.id        <= hit_id;
          sel_latched     <= 1'b1;
        end
      end
    end
  end

  assign sts_word        = sts_q;
  assign bus_reset_pulse = rst_evt;

endmodule

// File: rtl/scsi_sel_detect_chk.sv
module scsi_sel_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sts_valid,
  input logic       sts_ready,
  input logic [4:0] sts_word,
  input logic       sel_latched,
  input logic       bus_free_req,
  input logic       drv_en,
  input logic       drv_bsy,
  input logic       take_done,
  input logic       legacy_mode,
  input logic       ua_clear,
  input logic       bus_reset_pulse
);

  p_sts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_valid && !sts_ready && !bus_free_req && !bus_reset_pulse) |=> (sts_valid && $stable(sts_word)));

  p_sts_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> (sts_word[4] && sts_word[3]));

  p_supp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_bsy && !sts_valid) |=> !sts_valid);

  p_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_valid) |-> sel_latched);

  p_bsy_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_bsy |-> drv_en);

  p_bsy_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_bsy) |-> $past(drv_en));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_done |=> !take_done);

  p_ua_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ua_clear |-> take_done);

  p_ua_legacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ua_clear |=> legacy_mode);

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |=> !bus_reset_pulse);

  p_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_req |=> (!sts_valid && !drv_bsy && !drv_en && !sel_latched));

  p_busrst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_pulse |=> (!sts_valid && !drv_en && !legacy_mode));

endmodule

bind scsi_sel_detect scsi_sel_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sts_valid(sts_valid), .sts_ready(sts_ready),
  .sts_word(sts_word), .sel_latched(sel_latched), .bus_free_req(bus_free_req),
  .drv_en(drv_en), .drv_bsy(drv_bsy), .take_done(take_done),
  .legacy_mode(legacy_mode), .ua_clear(ua_clear), .bus_reset_pulse(bus_reset_pulse)
);

// File: tb/scsi_sel_detect_tb.sv
module scsi_sel_detect_tb;

  localparam int CLK_NS     = 10;
  localparam int NT         = 4;
  localparam int SETTLE_CYC = (100 + CLK_NS - 1) / CLK_NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 0, bus_bsy = 0, bus_atn = 0, bus_rst = 0;
  logic [7:0]    bus_data = 0;
  logic [NT-1:0] cfg_tgt_en;
  logic [NT*4-1:0] cfg_tgt_id;
  logic          sts_ready = 0, take_req = 0, bus_free_req = 0;
  logic          sts_valid, sel_latched, drv_en, drv_bsy, take_done;
  logic          atn_flag, legacy_mode, ua_clear, bus_reset_pulse;
  logic [4:0]    sts_word;

  int checks = 0, fails = 0;
  int n_done = 0, n_ua = 0, n_rev = 0;

  always #(CLK_NS/2) clk = ~clk;

  scsi_sel_detect #(.NUM_TGT(NT), .CLK_PERIOD_NS(CLK_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_bsy(bus_bsy), .bus_atn(bus_atn),
    .bus_rst(bus_rst), .bus_data(bus_data), .cfg_tgt_en(cfg_tgt_en), .cfg_tgt_id(cfg_tgt_id),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_word(sts_word), .sel_latched(sel_latched),
    .take_req(take_req), .bus_free_req(bus_free_req), .drv_en(drv_en), .drv_bsy(drv_bsy),
    .take_done(take_done), .atn_flag(atn_flag), .legacy_mode(legacy_mode), .ua_clear(ua_clear),
    .bus_reset_pulse(bus_reset_pulse)
  );

  always @(negedge clk) begin
    if (take_done) n_done++;
    if (ua_clear) n_ua++;
    if (bus_reset_pulse) n_rev++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_free();
    @(negedge clk) bus_free_req = 1;
    @(negedge clk) bus_free_req = 0;
    wait_n(2);
  endtask

  task automatic drop_sel();
    bus_sel = 0; bus_data = 0;
    wait_n(4);
  endtask

  task automatic t_reset_state();
    check("R1 reset outputs", {sts_valid, sel_latched, drv_en, drv_bsy, atn_flag, legacy_mode}, 0);
  endtask

  // slot0 id5, slot1 id2, slot2 id6 disabled, slot3 id9 (out of range)
  task automatic try_sel(input logic [7:0] d, input logic ev, input logic [2:0] eid, input string req);
    @(negedge clk) bus_data = d; bus_sel = 1;
    wait_n(5);
    check(req, sts_valid, ev);
    if (ev) check(req, sts_word, {2'b11, eid});
    drop_sel();
    bus_free();
  endtask

  task automatic t_id_match();
    try_sel(8'b0010_0100, 1, 3'd5, "R3 lowest slot wins");
    try_sel(8'b0000_0100, 1, 3'd2, "R3 single match");
    try_sel(8'b0100_0000, 0, 3'd0, "R3 disabled slot");
    try_sel(8'b0000_0010, 0, 3'd0, "R3 id above 7");
  endtask

  task automatic t_sel_bsy();
    @(negedge clk) bus_bsy = 1; bus_data = 8'h20; bus_sel = 1;
    wait_n(6);
    check("R2 no capture with BSY", sts_valid, 0);
    bus_bsy = 0;
    wait_n(5);
    check("R2 capture on BSY release", {sts_valid, sts_word}, {1'b1, 5'b11101});
    drop_sel();
    bus_free();
  endtask

  task automatic t_status_hold();
    logic stable_ok;
    @(negedge clk) bus_data = 8'h04; bus_sel = 1;
    wait_n(5);
    stable_ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!sts_valid || sts_word !== 5'b11010) stable_ok = 0;
    end
    check("R4 held without ready", stable_ok, 1);
    bus_sel = 0; wait_n(4);
    bus_data = 8'h20; bus_sel = 1; wait_n(5);
    check("R4 no overwrite while pending", {sts_valid, sts_word}, {1'b1, 5'b11010});
    sts_ready = 1;
    @(negedge clk) sts_ready = 0;
    check("R4 valid drops after accept", sts_valid, 0);
    drop_sel();
    bus_free();
  endtask

  task automatic t_short_sel();
    @(negedge clk) bus_data = 8'h04; bus_sel = 1;
    wait_n(3);
    bus_sel = 0; bus_data = 0;
    wait_n(20);
    check("R6 latched after SEL drop", {sel_latched, sts_valid}, 2'b11);
    bus_free();
    check("R6 latch cleared by bus free", sel_latched, 0);
  endtask

  task automatic take(input logic atn, input string req);
    int d0, u0;
    logic early;
    bus_atn = atn;
    wait_n(4);
    d0 = n_done; u0 = n_ua;
    @(negedge clk) take_req = 1;
    @(negedge clk) take_req = 0;
    check({req, " R7 enable first"}, {drv_en, drv_bsy}, 2'b10);
    @(negedge clk);
    check({req, " R7 BSY next"}, {drv_en, drv_bsy, take_done}, 3'b110);
    early = 0;
    for (int i = 0; i < SETTLE_CYC - 1; i++) begin
      @(negedge clk);
      if (take_done) early = 1;
    end
    check({req, " R7 no early done"}, early, 0);
    @(negedge clk);
    check({req, " R7 done at settle"}, take_done, 1);
    wait_n(1);
    check({req, " R8 mode and flag"}, {legacy_mode, atn_flag}, {!atn, atn});
    check({req, " R8 ua pulses"}, n_ua - u0, atn ? 0 : 1);
    check({req, " R7 one done"}, n_done - d0, 1);
  endtask

  task automatic t_takeover();
    int d0;
    take(0, "no-ATN");
    take_req = 1; @(negedge clk) take_req = 0;
    d0 = n_done;
    wait_n(SETTLE_CYC + 5);
    check("R11 repeat request ignored", {n_done - d0, drv_bsy}, {32'd0, 1'b1});
    bus_free();
    check("R10 bus free releases", {drv_en, drv_bsy, atn_flag, legacy_mode}, 4'b0001);
    take(1, "ATN");
    bus_free();
  endtask

  task automatic t_suppress();
    take(1, "suppress");
    @(negedge clk) bus_bsy = 0; bus_data = 8'h20; bus_sel = 1;
    wait_n(6);
    check("R5 no capture while driving BSY", {sts_valid, sel_latched}, 2'b00);
    drop_sel();
    bus_free();
  endtask

  task automatic t_rst_filter();
    int r0;
    r0 = n_rev;
    @(negedge clk) bus_rst = 1;
    wait_n(3);
    bus_rst = 0;
    wait_n(60);
    check("R9 glitch rejected", n_rev - r0, 0);
    @(negedge clk) bus_data = 8'h04; bus_sel = 1;
    wait_n(5);
    drop_sel();
    take(0, "pre-reset");
    check("R10 state before reset", {sts_valid, drv_bsy, legacy_mode}, 3'b111);
    bus_rst = 1;
    wait_n(70);
    bus_rst = 0;
    wait_n(4);
    check("R9 long reset accepted", n_rev - r0, 1);
    check("R10 bus reset clears", {sts_valid, sel_latched, drv_en, drv_bsy, legacy_mode}, 0);
  endtask

  bit done_flag = 0;

  initial begin
    cfg_tgt_en = 4'b1011;
    cfg_tgt_id = {4'd9, 4'd6, 4'd2, 4'd5};
    wait_n(3);
    rst_n = 1;
    wait_n(3);
    t_reset_state();
    t_id_match();
    t_sel_bsy();
    t_status_hold();
    t_short_sel();
    t_takeover();
    t_suppress();
    t_rst_filter();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule